// File: doc/BRIEF.md
# Prescaled Auto-Reload Down Timer

This block is a per-core down-counting timer driven from a small 32-bit word bus. Software programs a reload value, can overwrite the running count directly, and picks its operating mode through one control word. That word holds a run enable, a one-shot or auto-reload selector, an interrupt enable and an 8-bit prescale divisor. When the count runs out, the timer raises an event flag. An interrupt line follows that flag while interrupts are enabled. Software clears the flag by writing a one to its bit.

The counter moves down by one on every prescaled tick. A prescale value P gives one tick per P+1 clock cycles. When the counter is already zero and a tick arrives, that tick is an expiry. Auto-reload mode then copies the reload value back in and keeps going, and one-shot mode stops. With a divisor of zero, a zero reload or a zero count written by software gets special handling. In those cases the timer stops quietly, or it substitutes the reload value, and it does not produce a spurious expiry.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset, every register reads zero, the interrupt output is low and the counter stays put with no expiry.
- R2: Register offsets: 0x00 reload value, 0x04 live counter, 0x08 control, 0x0C event status (bit 0). Control bit 0 is run enable, bit 1 is auto-reload, bit 2 is interrupt enable, and bits 15:8 are the prescale value P. Unused control bits read zero. Every other offset reads zero. A write to the reload register also loads the counter.
- R3: While running, the counter decrements once every P+1 clock cycles. A write to reload, counter or control restarts the prescale phase. Starting from count N, the expiry comes (N+1)*(P+1) cycles after the start.
- R4: In one-shot mode, an expiry sets the event flag and stops the timer with the counter at zero.
- R5: In auto-reload mode, an expiry sets the event flag and copies the reload value into the counter, and counting goes on.
- R6: The interrupt output equals the event flag ANDed with control bit 2, and it follows a control or status write from the next cycle.
- R7: A status write clears the event flag when data bit 0 is one and leaves it alone when that bit is zero. An expiry in the same cycle takes precedence.
- R8: The timer counts only while enabled and while P is nonzero or the count is nonzero. A control write that enables the timer with P = 0 and count 0 in one-shot mode leaves it stopped.
- R9: In auto-reload mode with P = 0 and reload value 0, an expiry sets the flag once, and the timer then stops instead of firing again.
- R10: A zero written to the reload register while enabled with P = 0 stops the timer, clears the counter and does not set the flag.
- R11: With P = 0, a zero written to the counter in one-shot mode stops the timer with no flag. In auto-reload mode the written zero is replaced by the reload value.
- R12: A control write always re-evaluates the run state, so clearing enable halts the counter where it is. A write that enables auto-reload while the counter is zero first loads the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
A write is captured on one rising edge, and the register, the counter and the interrupt output show its effect right after that edge. Read data is combinational. Counter values are due k*(P+1) edges after a start, and an expiry lands (N+1)*(P+1) edges after the start. The bench drives each write for exactly one edge and waits a counted number of falling edges before sampling, so every check falls half a cycle after the edge that is supposed to produce its value. Both the cycle just before an expiry and the cycle just after it are sampled, which catches an off-by-one in either direction.

// File: rtl/trt_pkg.sv
package trt_pkg;
  localparam int BUS_W = 32;

  localparam logic [4:0] OFS_RELOAD = 5'h00;
  localparam logic [4:0] OFS_COUNT  = 5'h04;
  localparam logic [4:0] OFS_CTRL   = 5'h08;
  localparam logic [4:0] OFS_STAT   = 5'h0C;

  localparam int BIT_RUN_EN = 0;
  localparam int BIT_AUTO   = 1;
  localparam int BIT_IRQ_EN = 2;
  localparam int PRE_LSB    = 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RELOAD,
    SEL_COUNT,
    SEL_CTRL,
    SEL_STAT
  } reg_sel_e;
endpackage

// File: rtl/trt_prescaler.sv
module trt_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] divisor,
  output logic             tick
);
  logic [PRE_W-1:0] phase_q, phase_n;
  logic             wrap;

  assign wrap = (phase_q == divisor);
  assign tick = run && !restart && wrap;

  always_comb begin
    phase_n = phase_q;
    if (!run || restart || wrap) phase_n = '0;
    else                         phase_n = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_n;
  end

  // R3: with a nonzero divisor, two ticks never come on adjacent cycles
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor != '0) |=> !tick);
endmodule

// File: rtl/trt_count_core.sv
module trt_count_core #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_reload,
  input  logic             wr_count,
  input  logic             wr_ctrl,
  input  logic             clr_flag,
  input  logic [CNT_W-1:0] wval,
  input  logic             cur_en,
  input  logic             cur_auto,
  input  logic [PRE_W-1:0] cur_pre,
  input  logic             new_en,
  input  logic             new_auto,
  input  logic [PRE_W-1:0] new_pre,
  input  logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             flag_q,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_n, cnt_wr;
  logic             run_n;
  logic             pre_zero;

  assign pre_zero = (cur_pre == '0);
  assign expire   = tick && (cnt_q == '0);

  always_comb begin
    cnt_n  = cnt_q;
    run_n  = run_q;
    cnt_wr = wval;
    if (wr_reload) begin
      cnt_n = wval;
      run_n = cur_en && (!pre_zero || wval != '0);
    end else if (wr_count) begin
      if (cur_auto && pre_zero && wval == '0) cnt_wr = reload_q;
      cnt_n = cnt_wr;
      run_n = cur_en && (!pre_zero || cnt_wr != '0);
    end else if (wr_ctrl) begin
      cnt_wr = cnt_q;
      if (new_en && new_auto && cnt_q == '0) cnt_wr = reload_q;
      cnt_n = cnt_wr;
      run_n = new_en && (new_pre != '0 || cnt_wr != '0);
    end else if (tick) begin
      if (cnt_q != '0) begin
        cnt_n = cnt_q - 1'b1;
      end else if (cur_auto) begin
        cnt_n = reload_q;
        if (pre_zero && reload_q == '0) run_n = 1'b0;
      end else begin
        run_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      run_q  <= run_n;
      flag_q <= expire || (flag_q && !clr_flag);
    end
  end

  // R3: a tick on a nonzero count lowers it by exactly one
  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != '0) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));
  // R4: a stopped timer keeps its count unless software writes
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_reload && !wr_count && !wr_ctrl) |=> $stable(cnt_q));
  // R7: the flag rises only after an expiry
  assert_flag_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(expire));
  // R7: a clearing write without a competing expiry drops the flag
  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flag && !expire) |=> !flag_q);
endmodule

// File: rtl/prescaled_reload_timer.sv
module prescaled_reload_timer #(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  import trt_pkg::*;

  localparam int PRE_HI = PRE_LSB + PRE_W - 1;

  reg_sel_e         sel;
  logic             wr_reload, wr_count, wr_ctrl, wr_stat;
  logic             en_q, auto_q, irqen_q;
  logic [PRE_W-1:0] pre_q;
  logic             en_n, auto_n, irqen_n;
  logic [PRE_W-1:0] pre_n;
  logic [CNT_W-1:0] reload_q, reload_n;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, flag_q, expire, tick;

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFS_RELOAD): sel = SEL_RELOAD;
      ADDR_W'(OFS_COUNT):  sel = SEL_COUNT;
      ADDR_W'(OFS_CTRL):   sel = SEL_CTRL;
      ADDR_W'(OFS_STAT):   sel = SEL_STAT;
      default:             sel = SEL_NONE;
    endcase
  end

  assign wr_reload = bus_wr && (sel == SEL_RELOAD);
  assign wr_count  = bus_wr && (sel == SEL_COUNT);
  assign wr_ctrl   = bus_wr && (sel == SEL_CTRL);
  assign wr_stat   = bus_wr && (sel == SEL_STAT);

  assign en_n    = bus_wdata[BIT_RUN_EN];
  assign auto_n  = bus_wdata[BIT_AUTO];
  assign irqen_n = bus_wdata[BIT_IRQ_EN];
  assign pre_n   = bus_wdata[PRE_HI:PRE_LSB];
  assign reload_n = wr_reload ? bus_wdata[CNT_W-1:0] : reload_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      auto_q   <= 1'b0;
      irqen_q  <= 1'b0;
      pre_q    <= '0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q    <= en_n;
        auto_q  <= auto_n;
        irqen_q <= irqen_n;
        pre_q   <= pre_n;
      end
      reload_q <= reload_n;
    end
  end

  trt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .restart (wr_reload || wr_count || wr_ctrl),
    .divisor (pre_q),
    .tick    (tick)
  );

  trt_count_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wr_reload (wr_reload),
    .wr_count  (wr_count),
    .wr_ctrl   (wr_ctrl),
    .clr_flag  (wr_stat && bus_wdata[0]),
    .wval      (bus_wdata[CNT_W-1:0]),
    .cur_en    (en_q),
    .cur_auto  (auto_q),
    .cur_pre   (pre_q),
    .new_en    (en_n),
    .new_auto  (auto_n),
    .new_pre   (pre_n),
    .reload_q  (reload_q),
    .cnt_q     (cnt_q),
    .run_q     (run_q),
    .flag_q    (flag_q),
    .expire    (expire)
  );

  assign irq = flag_q && irqen_q;

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_RELOAD: bus_rdata[CNT_W-1:0] = reload_q;
      SEL_COUNT:  bus_rdata[CNT_W-1:0] = cnt_q;
      SEL_CTRL: begin
        bus_rdata[BIT_RUN_EN]     = en_q;
        bus_rdata[BIT_AUTO]       = auto_q;
        bus_rdata[BIT_IRQ_EN]     = irqen_q;
        bus_rdata[PRE_HI:PRE_LSB] = pre_q;
      end
      SEL_STAT:   bus_rdata[0] = flag_q;
      default:    bus_rdata = '0;
    endcase
  end

  // R8: the timer never runs while disabled
  assert_run_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> en_q);
  // R10: a zero reload while enabled with P = 0 leaves the timer stopped
  assert_zero_reload_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reload && en_q && pre_q == '0 && bus_wdata[CNT_W-1:0] == '0) |=> !run_q);
  // R6: an interrupt-enable write takes effect on the next cycle
  assert_irq_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !irqen_n) |=> !irq);
endmodule

// File: tb/prescaled_reload_timer_tb.sv
`timescale 1ns/100ps
module prescaled_reload_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  prescaled_reload_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_reg(input string req, input string what,
                         input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, what, v, exp);
  endtask

  task automatic quiesce();
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h1);
  endtask

  task automatic t_reset();
    chk_reg("R1", "reload", 5'h00, 32'h0);
    chk_reg("R1", "count", 5'h04, 32'h0);
    chk_reg("R1", "ctrl", 5'h08, 32'h0);
    chk_reg("R1", "status", 5'h0C, 32'h0);
    chk("R1", "irq", {31'h0, irq}, 32'h0);
    waitc(5);
    chk_reg("R1", "count idle", 5'h04, 32'h0);
    chk_reg("R1", "status idle", 5'h0C, 32'h0);
  endtask

  task automatic t_regmap();
    wr(5'h08, 32'h0000_AB06);
    chk_reg("R2", "ctrl fields", 5'h08, 32'h0000_AB06);
    wr(5'h08, 32'hFFFF_FFF8);
    chk_reg("R2", "ctrl unused bits", 5'h08, 32'h0000_FF00);
    wr(5'h08, 32'h0);
    wr(5'h00, 32'h0000_1234);
    chk_reg("R2", "reload readback", 5'h00, 32'h0000_1234);
    chk_reg("R2", "reload loads count", 5'h04, 32'h0000_1234);
    chk_reg("R2", "offset 0x10", 5'h10, 32'h0);
    chk_reg("R2", "offset 0x01", 5'h01, 32'h0);
    waitc(3);
    chk_reg("R8", "disabled holds", 5'h04, 32'h0000_1234);
  endtask

  task automatic t_oneshot();
    quiesce();
    wr(5'h00, 32'd5);
    wr(5'h08, 32'h5);
    chk_reg("R3", "start count", 5'h04, 32'd5);
    waitc(3);
    chk_reg("R3", "after 3", 5'h04, 32'd2);
    waitc(2);
    chk_reg("R4", "at zero", 5'h04, 32'd0);
    chk_reg("R4", "no flag yet", 5'h0C, 32'd0);
    waitc(1);
    chk_reg("R4", "flag set", 5'h0C, 32'd1);
    chk("R6", "irq on", {31'h0, irq}, 32'h1);
    waitc(4);
    chk_reg("R4", "stopped at zero", 5'h04, 32'd0);
    wr(5'h0C, 32'h0);
    chk_reg("R7", "zero write keeps flag", 5'h0C, 32'd1);
    wr(5'h0C, 32'h1);
    chk_reg("R7", "flag cleared", 5'h0C, 32'd0);
    chk("R6", "irq off after clear", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_prescale();
    quiesce();
    wr(5'h00, 32'd2);
    wr(5'h08, 32'h0000_0301);
    waitc(3);
    chk_reg("R3", "P=3 hold", 5'h04, 32'd2);
    waitc(1);
    chk_reg("R3", "P=3 first tick", 5'h04, 32'd1);
    waitc(4);
    chk_reg("R3", "P=3 zero", 5'h04, 32'd0);
    waitc(3);
    chk_reg("R3", "P=3 before expiry", 5'h0C, 32'd0);
    waitc(1);
    chk_reg("R3", "P=3 expiry", 5'h0C, 32'd1);
    chk("R6", "irq masked", {31'h0, irq}, 32'h0);
    wr(5'h08, 32'h0000_0305);
    chk("R6", "irq unmasked", {31'h0, irq}, 32'h1);
  endtask

  task automatic t_periodic();
    quiesce();
    wr(5'h00, 32'd3);
    wr(5'h08, 32'h3);
    waitc(3);
    chk_reg("R5", "before expiry", 5'h0C, 32'd0);
    waitc(1);
    chk_reg("R5", "expiry flag", 5'h0C, 32'd1);
    chk_reg("R5", "reloaded", 5'h04, 32'd3);
    wr(5'h0C, 32'h1);
    chk_reg("R5", "continues", 5'h04, 32'd2);
    chk_reg("R7", "cleared", 5'h0C, 32'd0);
    waitc(3);
    chk_reg("R5", "second expiry", 5'h0C, 32'd1);
    chk_reg("R5", "second reload", 5'h04, 32'd3);
  endtask

  task automatic t_runcond();
    quiesce();
    wr(5'h00, 32'd0);
    wr(5'h08, 32'h1);
    waitc(5);
    chk_reg("R8", "P0 count0 no flag", 5'h0C, 32'd0);
    chk_reg("R8", "P0 count0 count", 5'h04, 32'd0);
    wr(5'h08, 32'h0000_0201);
    waitc(2);
    chk_reg("R8", "P=2 pending", 5'h0C, 32'd0);
    waitc(1);
    chk_reg("R8", "P=2 expired", 5'h0C, 32'd1);
  endtask

  task automatic t_zero_reload_periodic();
    quiesce();
    wr(5'h00, 32'd0);
    wr(5'h08, 32'h3);
    wr(5'h04, 32'd2);
    chk_reg("R9", "count written", 5'h04, 32'd2);
    waitc(3);
    chk_reg("R9", "fires once", 5'h0C, 32'd1);
    chk_reg("R9", "count zero", 5'h04, 32'd0);
    wr(5'h0C, 32'h1);
    waitc(6);
    chk_reg("R9", "no refire", 5'h0C, 32'd0);
  endtask

  task automatic t_load_zero();
    quiesce();
    wr(5'h00, 32'd10);
    wr(5'h08, 32'h1);
    waitc(3);
    chk_reg("R10", "running", 5'h04, 32'd7);
    wr(5'h00, 32'd0);
    chk_reg("R10", "count cleared", 5'h04, 32'd0);
    waitc(20);
    chk_reg("R10", "no flag", 5'h0C, 32'd0);
    chk_reg("R10", "still zero", 5'h04, 32'd0);
  endtask

  task automatic t_count_zero();
    quiesce();
    wr(5'h00, 32'd10);
    wr(5'h08, 32'h1);
    waitc(2);
    wr(5'h04, 32'd0);
    waitc(15);
    chk_reg("R11", "oneshot no flag", 5'h0C, 32'd0);
    chk_reg("R11", "oneshot count", 5'h04, 32'd0);
    quiesce();
    wr(5'h00, 32'd6);
    wr(5'h08, 32'h3);
    waitc(2);
    chk_reg("R11", "periodic running", 5'h04, 32'd4);
    wr(5'h04, 32'd0);
    chk_reg("R11", "zero replaced", 5'h04, 32'd6);
    waitc(1);
    chk_reg("R11", "keeps running", 5'h04, 32'd5);
    chk_reg("R11", "no flag", 5'h0C, 32'd0);
  endtask

  task automatic t_ctrl();
    quiesce();
    wr(5'h00, 32'd8);
    wr(5'h08, 32'h1);
    waitc(2);
    wr(5'h08, 32'h0);
    chk_reg("R12", "halt value", 5'h04, 32'd6);
    waitc(5);
    chk_reg("R12", "halted", 5'h04, 32'd6);
    quiesce();
    wr(5'h00, 32'd2);
    wr(5'h08, 32'h1);
    waitc(3);
    chk_reg("R12", "oneshot done", 5'h04, 32'd0);
    wr(5'h0C, 32'h1);
    wr(5'h08, 32'h3);
    chk_reg("R12", "reload on enable", 5'h04, 32'd2);
    waitc(1);
    chk_reg("R12", "counting", 5'h04, 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    waitc(4);
    rst_n = 1'b1;
    waitc(1);
    t_reset();
    t_regmap();
    t_oneshot();
    t_prescale();
    t_periodic();
    t_runcond();
    t_zero_reload_periodic();
    t_load_zero();
    t_count_zero();
    t_ctrl();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule